// File: doc/BRIEF.md
# Switching-Cycle Fault Qualifier

This block sits between two protection comparators of an off-line switching converter and the shutdown path of its power switch. It decides, one switching cycle at a time, whether a comparator flag is a real fault or noise. The output-overvoltage flag only counts when it is read inside a short strobe window. That window opens a fixed delay after each switch turn-off, which skips the ringing that follows the edge. A fault is only declared after a run of consecutive cycles that each carry a hit. The second-level overcurrent flag works differently: its first trip only arms a warning, and a fault is declared if another trip comes in the very next switching cycle.

Both faults are registered, latched outputs that the shutdown logic of the switch can use directly. A latch stays set whatever its comparator does. It is released only by the supply undervoltage-lockout signal, which also restarts both qualifiers from their idle state. The oscillator supplies a one-clock cycle-start pulse, and the gate driver supplies a one-clock pulse at each turn-off. All timing is counted in clock cycles of the block's clock.

Top module: `cycle_fault_qual`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both `ovp_fault` and `ocp_fault` are 0.
- R2: `ovp_cmp` is ignored at every clock edge outside the strobe window. Four or more cycles in which the flag is high only outside the window latch no fault.
- R3: The strobe window samples `ovp_cmp` at clock edges k+1 for k = DLY_CLK … DLY_CLK+WIN_CLK−1, where edge 0 is the edge that samples `sw_off` high. A level present only at k = DLY_CLK−1 or k = DLY_CLK+WIN_CLK is not a hit.
- R4: When a `cyc_start` pulse closes a switching cycle that had no window hit, the consecutive-hit count returns to zero. Three hit cycles, one miss cycle and three more hit cycles latch no fault.
- R5: `ovp_fault` sets on the clock edge that samples the OVP_HITS-th consecutive hit (default 4), and is visible right after that edge.
- R6: Any number of window samples above threshold in one switching cycle count as a single hit.
- R7: A single overcurrent trip arms a warning only. If the next switching cycle has no trip, the logic returns to idle and no fault is latched.
- R8: Overcurrent trips in two consecutive switching cycles latch `ocp_fault`.
- R9: Several overcurrent trips inside one switching cycle count as one tripped cycle.
- R10: Once a fault is latched it stays at 1 whatever the comparator and strobe inputs do, until `uvlo` is asserted.
- R11: While `uvlo` is high, both faults are 0 from the next edge on. Afterwards both qualifiers start from zero hits and from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo | input | 1 | Supply undervoltage lockout; synchronous clear of both latches and all qualifier state |
| cyc_start | input | 1 | One-clock pulse at the start of each oscillator cycle |
| sw_off | input | 1 | One-clock pulse when the power switch turns off |
| ovp_cmp | input | 1 | Overvoltage comparator flag |
| ocp_cmp | input | 1 | Second-level overcurrent comparator flag |
| ovp_fault | output | 1 | Latched overvoltage fault |
| ocp_fault | output | 1 | Latched overcurrent fault |

## Verification
The properties rely on three conditions. `cyc_start` is a single-clock pulse that never lands on a strobe-window edge. Every switching cycle has at most one `sw_off` pulse. `uvlo` is taken only between switching cycles. The stimulus meets these conditions by building every cycle in one fixed order: cycle start, a short gap, turn-off, the full window span, any overcurrent trips, then idle clocks. Only the comparator levels and their positions inside this frame are chosen by the directed cases and the seeded random draws.

// File: rtl/cfq_pkg.sv
package cfq_pkg;

  typedef enum logic [1:0] {
    OCP_IDLE  = 2'd0,
    OCP_ARMED = 2'd1,
    OCP_WARN  = 2'd2
  } ocp_state_e;

  // True while the post-turn-off timer lies inside the sampling slot.
  function automatic logic in_window(input int unsigned t,
                                     input int unsigned dly,
                                     input int unsigned win);
    return (t >= dly) && (t < dly + win);
  endfunction

  // True when one more hit brings the running count to the limit.
  function automatic logic limit_reached(input int unsigned cnt,
                                         input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int unsigned DLY_CLK = 275,
  parameter int unsigned WIN_CLK = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_off,
  output logic win_open
);
  localparam int unsigned SPAN = DLY_CLK + WIN_CLK;
  localparam int unsigned TW   = $clog2(SPAN + 1);

  logic [TW-1:0] timer_q;
  logic          running_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q   <= '0;
      running_q <= 1'b0;
    end else if (sw_off) begin
      timer_q   <= '0;
      running_q <= 1'b1;
    end else if (running_q) begin
      if (32'(timer_q) == SPAN - 1) running_q <= 1'b0;
      timer_q <= timer_q + 1'b1;
    end
  end

  assign win_open = running_q && cfq_pkg::in_window(32'(timer_q), DLY_CLK, WIN_CLK);
endmodule

// File: rtl/ovp_qual.sv
module ovp_qual #(
  parameter int unsigned HITS = 4,
  localparam int unsigned CW  = $clog2(HITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cyc_start,
  input  logic          win_open,
  input  logic          ovp_cmp,
  output logic          hit_seen,
  output logic [CW-1:0] hit_cnt,
  output logic          fault
);
  logic hit;

  // First above-threshold sample of this cycle, taken only inside the window.
  assign hit = win_open && ovp_cmp && !hit_seen && !fault && !cyc_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt  <= '0;
      hit_seen <= 1'b0;
      fault    <= 1'b0;
    end else if (clr) begin
      hit_cnt  <= '0;
      hit_seen <= 1'b0;
      fault    <= 1'b0;
    end else if (!fault) begin
      if (cyc_start) begin
        if (!hit_seen) hit_cnt <= '0;
        hit_seen <= 1'b0;
      end else if (hit) begin
        hit_seen <= 1'b1;
        hit_cnt  <= hit_cnt + 1'b1;
        if (cfq_pkg::limit_reached(32'(hit_cnt), HITS)) fault <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ocp_qual.sv
module ocp_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cyc_start,
  input  logic ocp_cmp,
  output logic warn,
  output logic fault
);
  import cfq_pkg::*;

  ocp_state_e state_q, state_d;
  logic       fault_d;

  always_comb begin
    state_d = state_q;
    fault_d = fault;
    if (!fault) begin
      unique case (state_q)
        OCP_IDLE:  if (ocp_cmp) state_d = OCP_ARMED;
        OCP_ARMED: if (cyc_start) begin
                     if (ocp_cmp) fault_d = 1'b1;
                     else         state_d = OCP_WARN;
                   end
        OCP_WARN:  if (cyc_start) state_d = ocp_cmp ? OCP_ARMED : OCP_IDLE;
                   else if (ocp_cmp) fault_d = 1'b1;
        default:   state_d = OCP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OCP_IDLE;
      fault   <= 1'b0;
    end else if (clr) begin
      state_q <= OCP_IDLE;
      fault   <= 1'b0;
    end else begin
      state_q <= state_d;
      fault   <= fault_d;
    end
  end

  assign warn = (state_q == OCP_WARN);
endmodule

// File: rtl/cycle_fault_qual.sv
module cycle_fault_qual #(
  parameter int unsigned DLY_CLK  = 275,
  parameter int unsigned WIN_CLK  = 62,
  parameter int unsigned OVP_HITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  input  logic cyc_start,
  input  logic sw_off,
  input  logic ovp_cmp,
  input  logic ocp_cmp,
  output logic ovp_fault,
  output logic ocp_fault
);
  localparam int unsigned CW = $clog2(OVP_HITS + 1);

  // Internal events brought out by name for the checker.
  logic          win_open;
  logic          ovp_hit_seen;
  logic [CW-1:0] ovp_cnt;
  logic          ocp_warn;

  strobe_timer #(.DLY_CLK(DLY_CLK), .WIN_CLK(WIN_CLK)) u_strobe (
    .clk(clk), .rst_n(rst_n), .sw_off(sw_off), .win_open(win_open)
  );

  ovp_qual #(.HITS(OVP_HITS)) u_ovp (
    .clk(clk), .rst_n(rst_n), .clr(uvlo), .cyc_start(cyc_start),
    .win_open(win_open), .ovp_cmp(ovp_cmp), .hit_seen(ovp_hit_seen),
    .hit_cnt(ovp_cnt), .fault(ovp_fault)
  );

  ocp_qual u_ocp (
    .clk(clk), .rst_n(rst_n), .clr(uvlo), .cyc_start(cyc_start),
    .ocp_cmp(ocp_cmp), .warn(ocp_warn), .fault(ocp_fault)
  );
endmodule

// File: rtl/cfq_checker.sv
module cfq_checker #(
  parameter int unsigned HITS = 4,
  localparam int unsigned CW  = $clog2(HITS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uvlo,
  input logic          cyc_start,
  input logic          ovp_cmp,
  input logic          ocp_cmp,
  input logic          win_open,
  input logic          ovp_hit_seen,
  input logic [CW-1:0] ovp_cnt,
  input logic          ocp_warn,
  input logic          ovp_fault,
  input logic          ocp_fault
);
  AST_OVP_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_fault && !uvlo |=> ovp_fault); // R10
  AST_OCP_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_fault && !uvlo |=> ocp_fault); // R10
  AST_UVLO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !ovp_fault && !ocp_fault); // R11
  AST_OVP_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovp_fault) |-> $past(win_open && ovp_cmp)); // R2
  AST_OVP_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovp_fault) |-> 32'($past(ovp_cnt)) == HITS - 1); // R5
  AST_MISS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && !ovp_hit_seen && !ovp_fault && !uvlo |=> ovp_cnt == '0); // R4
  AST_OCP_RISE_NEEDS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_fault) |-> $past(ocp_cmp && (ocp_warn || cyc_start))); // R8
endmodule

bind cycle_fault_qual cfq_checker #(.HITS(OVP_HITS)) i_cfq_checker (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .cyc_start(cyc_start),
  .ovp_cmp(ovp_cmp), .ocp_cmp(ocp_cmp), .win_open(win_open),
  .ovp_hit_seen(ovp_hit_seen), .ovp_cnt(ovp_cnt), .ocp_warn(ocp_warn),
  .ovp_fault(ovp_fault), .ocp_fault(ocp_fault)
);

// File: tb/test_cycle_fault_qual.sv
`timescale 1ns/1ps
module test_cycle_fault_qual;
  localparam int DLY  = 275;
  localparam int WIN  = 62;
  localparam int HITS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, uvlo = 1'b0, cyc_start = 1'b0, sw_off = 1'b0;
  logic ovp_cmp = 1'b0, ocp_cmp = 1'b0;
  logic ovp_fault, ocp_fault;

  always #4 clk = ~clk;

  cycle_fault_qual #(.DLY_CLK(DLY), .WIN_CLK(WIN), .OVP_HITS(HITS)) i_cycle_fault_qual (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .cyc_start(cyc_start), .sw_off(sw_off),
    .ovp_cmp(ovp_cmp), .ocp_cmp(ocp_cmp), .ovp_fault(ovp_fault), .ocp_fault(ocp_fault)
  );

  int n_tests = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_ovp = 0, m_ocp = 0, m_prev_trip = 0;

  // Position modes: 0 none, 1 whole window, 2 only outside, 3 first slot,
  // 4 last slot, 5 one before window, 6 one after window.
  function automatic bit mode_hits(input int mode);
    return mode == 1 || mode == 3 || mode == 4;
  endfunction

  function automatic bit level_at(input int mode, input int k);
    case (mode)
      1: return k >= DLY && k < DLY + WIN;
      2: return k < DLY || k >= DLY + WIN;
      3: return k == DLY;
      4: return k == DLY + WIN - 1;
      5: return k == DLY - 1;
      6: return k == DLY + WIN;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input int mode, input int trips, input string tag);
    bit old_ovp, tr;
    old_ovp = m_ovp;
    if (!m_ovp) begin
      if (mode_hits(mode)) begin
        m_cnt++;
        if (m_cnt >= HITS) m_ovp = 1;
      end else m_cnt = 0;
    end
    tr = trips > 0;
    if (!m_ocp) begin
      if (tr && m_prev_trip) m_ocp = 1;
      m_prev_trip = tr;
    end
    cyc_start = 1; @(negedge clk); cyc_start = 0;
    repeat (3) @(negedge clk);
    sw_off = 1; @(negedge clk); sw_off = 0;
    for (int k = 0; k < DLY + WIN + 3; k++) begin
      ovp_cmp = level_at(mode, k);
      if (mode == 3 && k == DLY)     check({tag, " R5 before sampling edge"}, ovp_fault, old_ovp);
      if (mode == 3 && k == DLY + 1) check({tag, " R5 after sampling edge"}, ovp_fault, m_ovp);
      @(negedge clk);
    end
    ovp_cmp = 0;
    for (int t = 0; t < trips; t++) begin
      ocp_cmp = 1; @(negedge clk); ocp_cmp = 0; @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check({tag, " ovp_fault"}, ovp_fault, m_ovp);
    check({tag, " ocp_fault"}, ocp_fault, m_ocp);
  endtask

  task automatic do_uvlo();
    uvlo = 1; repeat (2) @(negedge clk);
    check("R11 ovp_fault under uvlo", ovp_fault, 1'b0);
    check("R11 ocp_fault under uvlo", ocp_fault, 1'b0);
    uvlo = 0; @(negedge clk);
    m_cnt = 0; m_ovp = 0; m_ocp = 0; m_prev_trip = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int modes[9] = '{1, 1, 1, 0, 2, 3, 4, 5, 6};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 ovp_fault in reset", ovp_fault, 1'b0);
    check("R1 ocp_fault in reset", ocp_fault, 1'b0);
    rst_n = 1; @(negedge clk);
    check("R1 ovp_fault after reset", ovp_fault, 1'b0);
    check("R1 ocp_fault after reset", ocp_fault, 1'b0);
    run_cycle(0, 0, "R1 idle");

    // Levels outside or just beside the window never count.
    for (int i = 0; i < 5; i++) run_cycle(2, 0, "R2 outside");
    for (int i = 0; i < 5; i++) run_cycle(5, 0, "R3 one before");
    for (int i = 0; i < 5; i++) run_cycle(6, 0, "R3 one after");
    // Window edges count; fourth hit latches at its own sampling edge.
    for (int i = 0; i < 3; i++) run_cycle(4, 0, "R3 last slot");
    run_cycle(3, 0, "R5 first slot 4th hit");
    run_cycle(0, 0, "R10 ovp held");
    do_uvlo();

    // Three hits then a miss, repeated; full windows count once each.
    for (int i = 0; i < 3; i++) run_cycle(1, 0, "R6 full window");
    run_cycle(0, 0, "R4 miss");
    for (int i = 0; i < 3; i++) run_cycle(1, 0, "R4 after miss");
    run_cycle(1, 0, "R5 fourth consecutive");
    run_cycle(2, 2, "R10 ovp held under activity");
    do_uvlo();
    for (int i = 0; i < 3; i++) run_cycle(1, 0, "R11 count restarted");
    run_cycle(0, 0, "R11 miss");

    // Overcurrent sequences.
    run_cycle(0, 1, "R7 single trip");
    run_cycle(0, 0, "R7 clean cycle");
    run_cycle(0, 1, "R7 single trip again");
    run_cycle(0, 0, "R7 back to idle");
    run_cycle(0, 2, "R9 double trip one cycle");
    run_cycle(0, 0, "R9 clean cycle");
    run_cycle(0, 1, "R8 first trip");
    run_cycle(0, 1, "R8 second trip");
    run_cycle(0, 0, "R10 ocp held");
    do_uvlo();
    run_cycle(0, 1, "R11 trip after clear");
    run_cycle(0, 0, "R11 idle after clear");

    // Seeded random cycles.
    for (int i = 0; i < 60; i++) begin
      int tr;
      tr = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 2);
      if ($urandom_range(0, 9) == 0) do_uvlo();
      run_cycle(modes[$urandom_range(0, 8)], tr, "R5 R8 random");
    end
    finish_run();
  end
endmodule